// File: doc/BRIEF.md
# Video Capture Front End

This block receives an 8-bit multiplexed 4:2:2 pixel stream on a 27 MHz pixel clock and turns it into luma and 4:2:0 chroma sample streams for a downstream encoder. The stream can carry its own timing through embedded BT.656 codes. It can also use separate horizontal and vertical sync wires with a field wire. Every sample comes out with a valid strobe. Frame-start, field-start and end-of-line pulses mark the picture structure.

Software-facing configuration inputs set the following:
- which pixel clock edge samples the inputs;
- progressive or interlaced operation;
- which field parity opens an interlaced frame;
- whether samples are clipped to the 16..240 range;
- how many input frames are dropped between kept frames.

A watchdog raises a flag when the camera stops delivering field starts. Frame sizes up to 720 samples per line are handled; the line width comes from the stream itself.

Top module: `vidcap_front`

## Requirements
- R1: With `i_fall_edge`=0, pixel, sync and field inputs are sampled on the rising clock edge. With 1, they are sampled on the falling edge. Values present only around the other edge have no effect.
- R2: When `i_bt656_mode`=0:
  - a byte is active video when both `i_hsync` and `i_vsync` are 0;
  - a rising `i_vsync` starts a field;
  - `i_field`=1 marks a top field and 0 a bottom field;
  - a line ends when active video stops.
- R3: When `i_bt656_mode`=1, the byte after FF 00 00 is a code byte XY. Its bit 6 is F (0 = top field, 1 = bottom field), bit 5 is V and bit 4 is H, and bits 3..0 are ignored. A code with V=0 and H=0 starts active video, and the next FF byte ends the line. A field starts at the first such code after a code with V=1.
- R4: Active bytes are taken in groups of four in the order Cb, Y0, Cr, Y1, counted from the start of each line. Every Y byte appears once on `o_y` with `o_y_valid`.
- R5: Within a field, line 0 is the first line:
  - chroma of even lines is stored and not output;
  - on each odd line, each Cb and Cr is output as (stored + current + 1) >> 1, in the order Cb, Cr per pixel pair;
  - `o_c_is_cr` is 1 for Cr.
- R6: With `i_clip_en`=1, every Y, Cb and Cr sample is limited to 16..240 inclusive before averaging and output. With 0, samples pass unchanged.
- R7: With `i_interlaced`=1, a frame starts only at a field whose parity equals `i_top_first` (1 = top). Fields seen before the first such field are discarded. With `i_interlaced`=0, every field start is a frame start.
- R8: `i_rate_sel` 0, 1, 2, 3 keeps one frame in 1, 2, 30, 60 respectively. The first frame after reset is kept, and nothing of a dropped frame is output.
- R9: For each kept frame, `o_sof` pulses once. For each kept field, `o_sofld` pulses once with `o_field_top` showing the field parity. For each kept line end, `o_eol` pulses once.
- R10: `o_cam_fault` rises when more than `i_vs_limit` clock cycles pass without a field start. It clears at the next field start.
- R11: During and right after reset, all output strobes and `o_cam_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | pixel clock |
| i_rst_n | input | 1 | asynchronous reset, active low |
| i_bt656_mode | input | 1 | 1 = embedded timing codes, 0 = sync wires |
| i_fall_edge | input | 1 | 1 = sample on falling edge |
| i_interlaced | input | 1 | 1 = two fields per frame |
| i_top_first | input | 1 | parity of the field that opens a frame |
| i_clip_en | input | 1 | enable 16..240 clipping |
| i_rate_sel | input | 2 | frame keep ratio select |
| i_vs_limit | input | WD_W | watchdog limit in clock cycles |
| i_pix | input | 8 | multiplexed pixel byte |
| i_hsync | input | 1 | horizontal blanking, active high |
| i_vsync | input | 1 | vertical sync, active high |
| i_field | input | 1 | 1 = top field |
| o_y_valid | output | 1 | luma sample strobe |
| o_y | output | 8 | luma sample |
| o_c_valid | output | 1 | chroma sample strobe |
| o_c | output | 8 | averaged chroma sample |
| o_c_is_cr | output | 1 | 1 = Cr, 0 = Cb |
| o_sof | output | 1 | kept frame start pulse |
| o_sofld | output | 1 | kept field start pulse |
| o_field_top | output | 1 | parity of the current field |
| o_eol | output | 1 | kept line end pulse |
| o_cam_fault | output | 1 | missing field start flag |

## Verification
The bench builds the block with MAX_PAIRS=8 and WD_W=12. The small line buffer lets pictures of two to four lines of one to four pixel pairs drive every line-pair averaging path in a few dozen cycles. Because of that, runs of 31 and 61 frames fit easily and reach the 1-in-30 and 1-in-60 keep points. The 12-bit watchdog counter lets a limit of 100 cycles show the fault rising and clearing within a short idle stretch.

// File: rtl/vcap_pkg.sv
`timescale 1ns/1ps
package vcap_pkg;
  typedef struct packed {
    logic [7:0] pix;
    logic       hs;
    logic       vs;
    logic       fld;
  } vin_t;

  localparam logic [7:0] LO_LIM = 8'd16;
  localparam logic [7:0] HI_LIM = 8'd240;

  function automatic logic [7:0] clip_sample(input logic [7:0] s, input logic en);
    if (!en)         return s;
    if (s < LO_LIM)  return LO_LIM;
    if (s > HI_LIM)  return HI_LIM;
    return s;
  endfunction

  function automatic logic [7:0] avg_round(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction

  function automatic logic [6:0] keep_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd1;
      2'd1:    return 7'd2;
      2'd2:    return 7'd30;
      default: return 7'd60;
    endcase
  endfunction
endpackage

// File: rtl/vcap_edge_sel.sv
`timescale 1ns/1ps
module vcap_edge_sel
  import vcap_pkg::*;
(
  input  logic i_clk,
  input  logic i_rst_n,
  input  logic i_fall,
  input  vin_t i_in,
  output vin_t o_smp
);
  localparam vin_t IDLE = '{pix: 8'h00, hs: 1'b1, vs: 1'b0, fld: 1'b0};

  vin_t rise_q, fall_q;

  always_ff @(posedge i_clk or negedge i_rst_n)
    if (!i_rst_n) rise_q <= IDLE;
    else          rise_q <= i_in;

  always_ff @(negedge i_clk or negedge i_rst_n)
    if (!i_rst_n) fall_q <= IDLE;
    else          fall_q <= i_in;

  always_ff @(posedge i_clk or negedge i_rst_n)
    if (!i_rst_n) o_smp <= IDLE;
    else          o_smp <= i_fall ? fall_q : rise_q;
endmodule

// File: rtl/vcap_sync.sv
`timescale 1ns/1ps
module vcap_sync
  import vcap_pkg::*;
(
  input  logic i_clk,
  input  logic i_rst_n,
  input  logic i_bt,
  input  vin_t i_smp,
  output logic o_act,
  output logic o_fld_start,
  output logic o_fld_top,
  output logic o_line_end
);
  logic [7:0] h0, h1, h2;
  logic       in_act, v_prev, act_d, vs_d;
  logic       code_hit, sav_go, ext_act;

  always_comb begin
    code_hit = (h2 == 8'hFF) && (h1 == 8'h00) && (h0 == 8'h00);
    sav_go   = code_hit && !i_smp.pix[5] && !i_smp.pix[4];
    ext_act  = !i_smp.hs && !i_smp.vs;
    if (i_bt) begin
      o_act       = in_act && (i_smp.pix != 8'hFF);
      o_line_end  = in_act && (i_smp.pix == 8'hFF);
      o_fld_start = sav_go && v_prev;
      o_fld_top   = ~i_smp.pix[6];
    end else begin
      o_act       = ext_act;
      o_line_end  = act_d && !ext_act;
      o_fld_start = i_smp.vs && !vs_d;
      o_fld_top   = i_smp.fld;
    end
  end

  always_ff @(posedge i_clk or negedge i_rst_n)
    if (!i_rst_n) begin
      h0 <= '0; h1 <= '0; h2 <= '0;
      in_act <= 1'b0; v_prev <= 1'b0; act_d <= 1'b0; vs_d <= 1'b0;
    end else begin
      h0 <= i_smp.pix; h1 <= h0; h2 <= h1;
      act_d <= ext_act;
      vs_d  <= i_smp.vs;
      if (code_hit) v_prev <= i_smp.pix[5];
      if (in_act && i_smp.pix == 8'hFF) in_act <= 1'b0;
      else if (sav_go)                  in_act <= 1'b1;
    end
endmodule

// File: rtl/vcap_frame.sv
`timescale 1ns/1ps
module vcap_frame
  import vcap_pkg::*;
(
  input  logic       i_clk,
  input  logic       i_rst_n,
  input  logic       i_interlaced,
  input  logic       i_top_first,
  input  logic [1:0] i_rate_sel,
  input  logic       i_fld_start,
  input  logic       i_fld_top,
  input  logic       i_line_end,
  output logic       o_keep,
  output logic       o_par,
  output logic       o_sof,
  output logic       o_sofld,
  output logic       o_top,
  output logic       o_eol
);
  logic [6:0] per;
  logic [5:0] cnt;
  logic       opens;

  assign per   = keep_period(i_rate_sel);
  assign opens = !i_interlaced || (i_fld_top == i_top_first);

  always_ff @(posedge i_clk or negedge i_rst_n)
    if (!i_rst_n) begin
      cnt <= '0; o_keep <= 1'b0; o_par <= 1'b0; o_top <= 1'b0;
      o_sof <= 1'b0; o_sofld <= 1'b0; o_eol <= 1'b0;
    end else begin
      o_sof <= 1'b0; o_sofld <= 1'b0; o_eol <= 1'b0;
      if (i_fld_start) begin
        o_top <= i_fld_top;
        o_par <= 1'b0;
        if (opens) begin
          o_keep  <= (cnt == 6'd0);
          o_sof   <= (cnt == 6'd0);
          o_sofld <= (cnt == 6'd0);
          cnt     <= ({1'b0, cnt} >= per - 7'd1) ? 6'd0 : cnt + 6'd1;
        end else begin
          o_sofld <= o_keep;
        end
      end else if (i_line_end) begin
        o_par <= ~o_par;
        o_eol <= o_keep;
      end
    end

  // R9
  sof_with_field_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_sof |-> o_sofld);
  // R7
  frame_parity_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (o_sof && $past(i_interlaced)) |-> (o_top == $past(i_top_first)));
endmodule

// File: rtl/vcap_chroma.sv
`timescale 1ns/1ps
module vcap_chroma
  import vcap_pkg::*;
#(
  parameter int MAX_PAIRS = 360
) (
  input  logic       i_clk,
  input  logic       i_rst_n,
  input  logic       i_act,
  input  logic [7:0] i_px,
  input  logic       i_restart,
  input  logic       i_keep,
  input  logic       i_par,
  output logic       o_y_valid,
  output logic [7:0] o_y,
  output logic       o_c_valid,
  output logic [7:0] o_c,
  output logic       o_c_is_cr
);
  localparam int CW    = $clog2(MAX_PAIRS + 1);
  localparam int AW    = CW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] COL_END = CW'(MAX_PAIRS);

  logic [7:0]    lbuf [DEPTH];
  logic [1:0]    ph;
  logic [CW-1:0] col;
  logic [AW-1:0] addr;
  logic          is_c, in_rng;

  assign is_c   = !ph[0];
  assign in_rng = (col != COL_END);
  assign addr   = {col, ph[1]};

  always_ff @(posedge i_clk)
    if (i_act && is_c && !i_par && in_rng) lbuf[addr] <= i_px;

  always_ff @(posedge i_clk or negedge i_rst_n)
    if (!i_rst_n) begin
      ph <= '0; col <= '0;
      o_y_valid <= 1'b0; o_y <= '0;
      o_c_valid <= 1'b0; o_c <= '0; o_c_is_cr <= 1'b0;
    end else begin
      o_y_valid <= i_act && ph[0] && i_keep;
      o_y       <= i_px;
      o_c_valid <= i_act && is_c && i_par && i_keep && in_rng;
      o_c       <= avg_round(lbuf[addr], i_px);
      o_c_is_cr <= ph[1];
      if (i_restart) begin
        ph <= '0; col <= '0;
      end else if (i_act) begin
        ph <= ph + 2'd1;
        if (ph == 2'd3 && in_rng) col <= col + 1'b1;
      end
    end

  // R4
  luma_chroma_excl_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    $onehot0({o_y_valid, o_c_valid}));
  // R5
  chroma_odd_line_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_c_valid |-> $past(i_par));
endmodule

// File: rtl/vidcap_front.sv
`timescale 1ns/1ps
module vidcap_front
  import vcap_pkg::*;
#(
  parameter int MAX_PAIRS = 360,
  parameter int WD_W      = 21
) (
  input  logic            i_clk,
  input  logic            i_rst_n,
  input  logic            i_bt656_mode,
  input  logic            i_fall_edge,
  input  logic            i_interlaced,
  input  logic            i_top_first,
  input  logic            i_clip_en,
  input  logic [1:0]      i_rate_sel,
  input  logic [WD_W-1:0] i_vs_limit,
  input  logic [7:0]      i_pix,
  input  logic            i_hsync,
  input  logic            i_vsync,
  input  logic            i_field,
  output logic            o_y_valid,
  output logic [7:0]      o_y,
  output logic            o_c_valid,
  output logic [7:0]      o_c,
  output logic            o_c_is_cr,
  output logic            o_sof,
  output logic            o_sofld,
  output logic            o_field_top,
  output logic            o_eol,
  output logic            o_cam_fault
);
  vin_t       raw_in, smp;
  logic       act, fld_start, fld_top, line_end, keep, par;
  logic [7:0] px_clip;
  logic [WD_W-1:0] wd_cnt;

  assign raw_in = '{pix: i_pix, hs: i_hsync, vs: i_vsync, fld: i_field};

  vcap_edge_sel u_edge (.i_clk(i_clk), .i_rst_n(i_rst_n), .i_fall(i_fall_edge),
                        .i_in(raw_in), .o_smp(smp));

  vcap_sync u_sync (.i_clk(i_clk), .i_rst_n(i_rst_n), .i_bt(i_bt656_mode), .i_smp(smp),
                    .o_act(act), .o_fld_start(fld_start), .o_fld_top(fld_top),
                    .o_line_end(line_end));

  vcap_frame u_frame (.i_clk(i_clk), .i_rst_n(i_rst_n), .i_interlaced(i_interlaced),
                      .i_top_first(i_top_first), .i_rate_sel(i_rate_sel),
                      .i_fld_start(fld_start), .i_fld_top(fld_top), .i_line_end(line_end),
                      .o_keep(keep), .o_par(par), .o_sof(o_sof), .o_sofld(o_sofld),
                      .o_top(o_field_top), .o_eol(o_eol));

  assign px_clip = clip_sample(smp.pix, i_clip_en);

  vcap_chroma #(.MAX_PAIRS(MAX_PAIRS)) u_chroma (
    .i_clk(i_clk), .i_rst_n(i_rst_n), .i_act(act), .i_px(px_clip),
    .i_restart(fld_start || line_end), .i_keep(keep), .i_par(par),
    .o_y_valid(o_y_valid), .o_y(o_y), .o_c_valid(o_c_valid), .o_c(o_c),
    .o_c_is_cr(o_c_is_cr));

  always_ff @(posedge i_clk or negedge i_rst_n)
    if (!i_rst_n) begin
      wd_cnt <= '0; o_cam_fault <= 1'b0;
    end else if (fld_start) begin
      wd_cnt <= '0; o_cam_fault <= 1'b0;
    end else begin
      if (wd_cnt != '1) wd_cnt <= wd_cnt + 1'b1;
      if (wd_cnt >= i_vs_limit) o_cam_fault <= 1'b1;
    end

  // R6
  clip_range_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (o_y_valid && $past(i_clip_en)) |-> (o_y >= 8'd16 && o_y <= 8'd240));
  // R10
  fault_clear_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    fld_start |=> !o_cam_fault);
endmodule

// File: tb/test_vidcap_front.sv
`timescale 1ns/1ps
module test_vidcap_front;
  localparam int MP  = 8;
  localparam int WDW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic bt = 0, fall_cfg = 0, ilace = 0, topf = 1, clip = 0;
  logic [1:0] rate = 0;
  logic [WDW-1:0] lim = 12'd4000;
  logic [7:0] pix = 8'h10;
  logic hs = 1, vs = 0, fld = 0;
  logic y_v, c_v, c_cr, sof, sofld, ftop, eol, fault;
  logic [7:0] y, c;

  bit fall_drv = 0;
  int n_chk = 0, n_bad = 0;
  int got_y[$], exp_y[$], got_c[$], exp_c[$], tops[$];
  int n_sof = 0, n_fld = 0, n_eol = 0;

  vidcap_front #(.MAX_PAIRS(MP), .WD_W(WDW)) i_vidcap_front (
    .i_clk(clk), .i_rst_n(rst_n), .i_bt656_mode(bt), .i_fall_edge(fall_cfg),
    .i_interlaced(ilace), .i_top_first(topf), .i_clip_en(clip), .i_rate_sel(rate),
    .i_vs_limit(lim), .i_pix(pix), .i_hsync(hs), .i_vsync(vs), .i_field(fld),
    .o_y_valid(y_v), .o_y(y), .o_c_valid(c_v), .o_c(c), .o_c_is_cr(c_cr),
    .o_sof(sof), .o_sofld(sofld), .o_field_top(ftop), .o_eol(eol), .o_cam_fault(fault));

  always @(negedge clk) if (rst_n) begin
    if (y_v) got_y.push_back(int'(y));
    if (c_v) got_c.push_back(int'({c_cr, c}));
    if (sof) n_sof++;
    if (sofld) begin n_fld++; tops.push_back(int'(ftop)); end
    if (eol) n_eol++;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_q(input string req, ref int a[$], ref int e[$]);
    int bad = -1;
    for (int i = 0; i < e.size() && i < a.size(); i++)
      if (bad < 0 && a[i] != e[i]) bad = i;
    if (bad < 0 && a.size() != e.size())
      check(0, {req, " sample count"}, a.size(), e.size());
    else if (bad >= 0)
      check(0, $sformatf("%s sample %0d", req, bad), a[bad], e[bad]);
    else
      check(1, req, 0, 0);
  endtask

  // one input byte per clock, valid only around the sampling edge chosen by fall_drv
  task automatic put(input logic [7:0] b, input logic h, input logic v, input logic f);
    if (!fall_drv) @(negedge clk); else @(posedge clk);
    #0.5; pix = b; hs = h; vs = v; fld = f;
    if (!fall_drv) @(posedge clk); else @(negedge clk);
    #0.5; pix = 8'h5A; hs = 1; vs = 0; fld = 0;
  endtask

  function automatic int pv(int base, int l, int i);
    return 1 + ((base + l * 29 + i * 7) % 254);
  endfunction

  function automatic int clipv(int v, bit en);
    if (!en) return v;
    return (v < 16) ? 16 : (v > 240) ? 240 : v;
  endfunction

  task automatic expect_field(int base, int lines, int pairs, bit cl);
    for (int l = 0; l < lines; l++)
      for (int i = 0; i < 4 * pairs; i++) begin
        int v = clipv(pv(base, l, i), cl);
        if (i % 2 == 1) exp_y.push_back(v);
        else if (l % 2 == 1) begin
          int p = clipv(pv(base, l - 1, i), cl);
          exp_c.push_back(((i % 4 == 2) ? 256 : 0) + (p + v + 1) / 2);
        end
      end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) put(8'h10, 1, 0, 0);
  endtask

  task automatic clear();
    got_y.delete(); exp_y.delete(); got_c.delete(); exp_c.delete(); tops.delete();
    n_sof = 0; n_fld = 0; n_eol = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle(3); rst_n = 1; idle(2); clear();
  endtask

  task automatic ext_frame(int base, int lines, int pairs, logic f);
    for (int k = 0; k < 3; k++) put(8'h10, 1, 1, f);
    for (int l = 0; l < lines; l++) begin
      put(8'h10, 1, 0, f); put(8'h10, 1, 0, f);
      for (int i = 0; i < 4 * pairs; i++) put(8'(pv(base, l, i)), 0, 0, f);
    end
    put(8'h10, 1, 0, f); put(8'h10, 1, 0, f);
  endtask

  task automatic bt_code(logic F, logic V, logic H);
    put(8'hFF, 0, 0, 0); put(8'h00, 0, 0, 0); put(8'h00, 0, 0, 0);
    put({1'b1, F, V, H, 4'b0000}, 0, 0, 0);
  endtask

  task automatic bt_field(int base, int lines, int pairs, logic F);
    bt_code(F, 1, 1); put(8'h80, 0, 0, 0); put(8'h10, 0, 0, 0);
    bt_code(F, 1, 0); put(8'h80, 0, 0, 0); put(8'h10, 0, 0, 0);
    for (int l = 0; l < lines; l++) begin
      bt_code(F, 0, 0);
      for (int i = 0; i < 4 * pairs; i++) put(8'(pv(base, l, i)), 0, 0, 0);
      bt_code(F, 0, 1); put(8'h80, 0, 0, 0); put(8'h10, 0, 0, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; idle(2);
    check(y_v == 0 && c_v == 0 && sof == 0 && sofld == 0 && eol == 0, "R11 strobes in reset",
          int'({y_v, c_v, sof, sofld, eol}), 0);
    rst_n = 1; idle(3);
    check(fault == 0 && y_v == 0, "R11 after reset", int'({fault, y_v}), 0);
  endtask

  task automatic t_ext_basic();
    bt = 0; ilace = 0; clip = 0; rate = 0; fall_cfg = 0; fall_drv = 0;
    do_reset();
    ext_frame(3, 4, 4, 0); expect_field(3, 4, 4, 0);
    ext_frame(100, 4, 4, 1); expect_field(100, 4, 4, 0);
    idle(4);
    cmp_q("R2 R4 luma order", got_y, exp_y);
    cmp_q("R5 chroma average", got_c, exp_c);
    check(n_sof == 2, "R9 frame pulses", n_sof, 2);
    check(n_fld == 2, "R9 field pulses", n_fld, 2);
    check(n_eol == 8, "R9 line end pulses", n_eol, 8);
  endtask

  task automatic t_clip();
    clip = 1; do_reset();
    ext_frame(211, 4, 4, 0); expect_field(211, 4, 4, 1);
    idle(4);
    cmp_q("R6 clipped luma", got_y, exp_y);
    cmp_q("R6 clipped chroma", got_c, exp_c);
    clip = 0;
  endtask

  task automatic t_edge();
    fall_cfg = 1; fall_drv = 1; do_reset();
    ext_frame(40, 2, 3, 0); expect_field(40, 2, 3, 0);
    idle(4);
    cmp_q("R1 falling edge capture", got_y, exp_y);
    fall_cfg = 0; do_reset();
    ext_frame(40, 2, 3, 0); idle(4);
    check(got_y.size() == 0 && n_sof == 0, "R1 wrong edge ignored", got_y.size(), 0);
    fall_drv = 0;
  endtask

  task automatic t_skip();
    rate = 1; do_reset();
    for (int k = 0; k < 4; k++) begin
      ext_frame(10 * k, 2, 2, 0);
      if (k % 2 == 0) expect_field(10 * k, 2, 2, 0);
    end
    idle(4);
    cmp_q("R8 half rate data", got_y, exp_y);
    check(n_sof == 2, "R8 half rate frames", n_sof, 2);
    rate = 2; do_reset();
    for (int k = 0; k < 31; k++) ext_frame(k, 2, 1, 0);
    idle(4);
    check(n_sof == 2, "R8 one in thirty", n_sof, 2);
    rate = 3; do_reset();
    for (int k = 0; k < 61; k++) begin
      ext_frame(k, 2, 1, 0);
      if (k == 0 || k == 60) expect_field(k, 2, 1, 0);
    end
    idle(4);
    check(n_sof == 2, "R8 one in sixty", n_sof, 2);
    cmp_q("R8 one in sixty data", got_y, exp_y);
    rate = 0;
  endtask

  task automatic t_bt(bit tf);
    bt = 1; ilace = 1; topf = tf; do_reset();
    // first field has the wrong parity for a frame start and is discarded
    bt_field(5, 2, 3, tf ? 1'b1 : 1'b0);
    bt_field(50, 2, 3, tf ? 1'b0 : 1'b1); expect_field(50, 2, 3, 0);
    bt_field(90, 2, 3, tf ? 1'b1 : 1'b0); expect_field(90, 2, 3, 0);
    idle(4);
    cmp_q(tf ? "R3 R7 top first luma" : "R7 bottom first luma", got_y, exp_y);
    cmp_q("R3 field chroma", got_c, exp_c);
    check(n_sof == 1, "R7 one frame", n_sof, 1);
    check(tops.size() == 2 && tops[0] == int'(tf) && tops[1] == int'(!tf),
          "R9 field parity markers", tops.size() > 0 ? tops[0] : -1, int'(tf));
    check(n_eol == 4, "R3 line ends", n_eol, 4);
    bt = 0; ilace = 0; topf = 1;
  endtask

  task automatic t_watchdog();
    lim = 12'd100; do_reset();
    idle(60);
    check(fault == 0, "R10 before limit", fault, 0);
    idle(100);
    check(fault == 1, "R10 after limit", fault, 1);
    ext_frame(1, 2, 1, 0); idle(2);
    check(fault == 0, "R10 cleared by field", fault, 0);
    lim = 12'd4000;
  endtask

  initial begin
    t_reset();
    t_ext_basic();
    t_clip();
    t_edge();
    t_skip();
    t_bt(1);
    t_bt(0);
    t_watchdog();
    summary();
    $finish;
  end
endmodule